// File: doc/BRIEF.md
# Alarm-Driven Power Enable Controller

This block drives the enable pin of an external power-management supply from a real-time clock. Software programs a second alarm time. When the running time, presented on each time-update strobe, equals that alarm, a sticky status flag is set. If power control has been enabled, the power enable output also falls to its OFF level, which shuts the system down. The shortest shutdown delay is therefore one time step: the alarm has to be written before the next update arrives.

Power returns through a set of external wake pins. Each pin has its own enable bit and its own polarity bit, and is passed through a multi-stage synchronizer before use. While the output is OFF, any enabled wake pin at its active level drives the output back ON. All configuration writes are guarded by a write-protect sequence of two key words. An alarm interrupt output is the status flag gated by its enable.

Top module: `alarm_pwr_ctl`

## Requirements
- R1: After reset, pwr_en is 1 (ON), alarm_irq is 0, the control register (address 2) and status register (address 3) read 0, and the protect register (address 0) reads 0 (locked).
- R2: While locked, writes to the alarm register (address 1), control register (address 2) and status register (address 3) have no effect. Reads are always allowed.
- R3: A time strobe (time_tick=1) whose time_now equals the alarm value sets status bit 0 at the next clock edge. A mismatch, or a match without the strobe, does not set it. Writing 1 to status bit 0 while unlocked clears it, and writing 0 leaves it set.
- R4: alarm_irq equals status bit 0 AND control bit 1 (interrupt enable).
- R5: On an alarm hit with control bit 0 (power control) set, pwr_en goes to 0 at the same clock edge that sets the flag. With control bit 0 clear, pwr_en stays 1.
- R6: Wake pin i is enabled by control bit 8+i. While pwr_en is 0, an enabled pin at its active level sets pwr_en to 1 on the third clock edge after the pin changes: two synchronizer stages plus the output register. A disabled pin has no effect.
- R7: Control bit 16+i picks the polarity of wake pin i: 0 (the reset value) means active low, and 1 means active high.
- R8: A wake pin restores power only from OFF. An alarm hit while ON turns power OFF even if a wake is active, and the output then returns ON at the following edge.
- R9: Writing key 32'h5A3C_0F11 and then key 32'hA5C3_F0EE to address 0 unlocks, and address 0 then reads 1. Any other write to address 0 locks, including a wrong second key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | TIME_W | Current time value |
| time_tick | input | 1 | Strobe: time_now was just updated |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| wake_pin | input | N_WAKE | Asynchronous external wake pins |
| pwr_en | output | 1 | Power enable (1 = ON, 0 = OFF) |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The bench builds the block with TIME_W=24, which holds a six-digit BCD time. It uses N_WAKE=2, so opposite polarities can be tested side by side, and SYNC_STAGES=2, so the three-edge wake latency can be checked both one edge early and exactly on time. With two pins, one pin is left disabled while it sits at its active level, and the other is held active through an alarm to show that OFF takes priority while ON.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
   localparam int ADDR_W = 2;
   localparam int BUS_W  = 32;

   typedef enum logic [1:0] {
      A_KEY   = 2'd0,
      A_ALARM = 2'd1,
      A_CTRL  = 2'd2,
      A_STAT  = 2'd3
   } reg_addr_e;

   typedef enum logic [1:0] {
      WP_LOCKED = 2'd0,
      WP_HALF   = 2'd1,
      WP_OPEN   = 2'd2
   } wp_state_e;

   localparam logic [BUS_W-1:0] KEY_A = 32'h5A3C_0F11;
   localparam logic [BUS_W-1:0] KEY_B = 32'hA5C3_F0EE;

   localparam int CTL_PWR_BIT  = 0;
   localparam int CTL_IRQ_BIT  = 1;
   localparam int WAKE_EN_LSB  = 8;
   localparam int WAKE_POL_LSB = 16;
endpackage

// File: rtl/pwr_wp_lock.sv
module pwr_wp_lock
   import pwrseq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kick_wr,
   input  logic [BUS_W-1:0] kick_data,
   output logic             unlocked
);
   wp_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (kick_wr) begin
         if (kick_data == KEY_A)
            state_d = WP_HALF;
         else if (state_q == WP_HALF && kick_data == KEY_B)
            state_d = WP_OPEN;
         else
            state_d = WP_LOCKED;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= WP_LOCKED;
      else        state_q <= state_d;
   end

   assign unlocked = (state_q == WP_OPEN);

   // R9: the open state is only entered from the half-keyed state
   p_open_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == WP_OPEN && $past(state_q) != WP_OPEN) |-> $past(state_q) == WP_HALF);
endmodule

// File: rtl/pwr_alarm_cmp.sv
module pwr_alarm_cmp #(
   parameter int TIME_W = 24
) (
   input  logic [TIME_W-1:0] time_now,
   input  logic              time_tick,
   input  logic [TIME_W-1:0] alarm_val,
   output logic              hit
);
   localparam int NIB = (TIME_W + 3) / 4;
   logic [NIB-1:0] nib_eq;

   for (genvar g = 0; g < NIB; g++) begin : g_nib
      localparam int LO = 4 * g;
      localparam int HI = (LO + 3 < TIME_W) ? LO + 3 : TIME_W - 1;
      assign nib_eq[g] = (time_now[HI:LO] == alarm_val[HI:LO]);
   end

   assign hit = time_tick && (&nib_eq);
endmodule

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
   parameter int N_WAKE      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_WAKE-1:0] pin_async,
   output logic [N_WAKE-1:0] pin_sync
);
   if (SYNC_STAGES < 2) begin : g_bad
      $error("pwr_wake_sync: SYNC_STAGES must be at least 2");
   end

   for (genvar i = 0; i < N_WAKE; i++) begin : g_pin
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[SYNC_STAGES-2:0], pin_async[i]};
      end
      assign pin_sync[i] = sh_q[SYNC_STAGES-1];
   end
endmodule

// File: rtl/alarm_pwr_ctl.sv
module alarm_pwr_ctl
   import pwrseq_pkg::*;
#(
   parameter int TIME_W      = 24,
   parameter int N_WAKE      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_now,
   input  logic              time_tick,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [N_WAKE-1:0] wake_pin,
   output logic              pwr_en,
   output logic              alarm_irq
);
   if (TIME_W < 1 || TIME_W > BUS_W) begin : g_bad_time
      $error("alarm_pwr_ctl: TIME_W must be 1..32");
   end
   if (N_WAKE < 1 || N_WAKE > 8) begin : g_bad_wake
      $error("alarm_pwr_ctl: N_WAKE must be 1..8");
   end

   logic              unlocked, wr_open, a2_hit, a2_flag, wake_any;
   logic              ctl_pwr, ctl_irq;
   logic [N_WAKE-1:0] wake_en, wake_pol, wake_s, wake_act;
   logic [TIME_W-1:0] alarm_q;

   pwr_wp_lock u_lock (
      .clk(clk), .rst_n(rst_n),
      .kick_wr(bus_wr && bus_addr == A_KEY),
      .kick_data(bus_wdata), .unlocked(unlocked));

   pwr_alarm_cmp #(.TIME_W(TIME_W)) u_cmp (
      .time_now(time_now), .time_tick(time_tick),
      .alarm_val(alarm_q), .hit(a2_hit));

   pwr_wake_sync #(.N_WAKE(N_WAKE), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_async(wake_pin), .pin_sync(wake_s));

   assign wr_open = bus_wr && unlocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q  <= '0;
         ctl_pwr  <= 1'b0;
         ctl_irq  <= 1'b0;
         wake_en  <= '0;
         wake_pol <= '0;
      end else if (wr_open) begin
         if (bus_addr == A_ALARM) alarm_q <= bus_wdata[TIME_W-1:0];
         if (bus_addr == A_CTRL) begin
            ctl_pwr  <= bus_wdata[CTL_PWR_BIT];
            ctl_irq  <= bus_wdata[CTL_IRQ_BIT];
            wake_en  <= bus_wdata[WAKE_EN_LSB +: N_WAKE];
            wake_pol <= bus_wdata[WAKE_POL_LSB +: N_WAKE];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         a2_flag <= 1'b0;
      else if (a2_hit)
         a2_flag <= 1'b1;
      else if (wr_open && bus_addr == A_STAT && bus_wdata[0])
         a2_flag <= 1'b0;
   end

   for (genvar i = 0; i < N_WAKE; i++) begin : g_act
      if (1) begin : g_pol
         assign wake_act[i] = wake_en[i] && (wake_pol[i] ? wake_s[i] : !wake_s[i]);
      end
   end
   assign wake_any = |wake_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    pwr_en <= 1'b1;
      else if (!pwr_en && wake_any)  pwr_en <= 1'b1;
      else if (a2_hit && ctl_pwr)    pwr_en <= 1'b0;
   end

   assign alarm_irq = a2_flag && ctl_irq;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_KEY:   bus_rdata[0] = unlocked;
         A_ALARM: bus_rdata[TIME_W-1:0] = alarm_q;
         A_CTRL: begin
            bus_rdata[CTL_PWR_BIT] = ctl_pwr;
            bus_rdata[CTL_IRQ_BIT] = ctl_irq;
            bus_rdata[WAKE_EN_LSB +: N_WAKE]  = wake_en;
            bus_rdata[WAKE_POL_LSB +: N_WAKE] = wake_pol;
         end
         default: bus_rdata[0] = a2_flag;
      endcase
   end

   // R2: a locked control write leaves the control state unchanged
   p_locked_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !unlocked && bus_addr == A_CTRL) |=> ($stable(ctl_pwr) && $stable(wake_en)));
   // R3: a hit sets the flag
   p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      a2_hit |=> a2_flag);
   // R3: the flag only falls after an unlocked write-one to status
   p_flag_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(a2_flag) |-> $past(wr_open && bus_addr == A_STAT && bus_wdata[0]));
   // R4: the interrupt never shows without the flag
   p_irq_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> a2_flag);
   // R5: a controlled hit while ON switches OFF
   p_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (a2_hit && ctl_pwr && pwr_en) |=> !pwr_en);
   // R5: power only falls after a controlled hit
   p_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en) |-> $past(a2_hit && ctl_pwr));
   // R6: an active enabled wake restores power from OFF
   p_wake_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_en && wake_any) |=> pwr_en);
endmodule

// File: tb/alarm_pwr_ctl_bench.sv
module alarm_pwr_ctl_bench;
   localparam int TIME_W = 24;
   localparam int N_WAKE = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [TIME_W-1:0] time_now = '0;
   logic              time_tick = 1'b0;
   logic              bus_wr = 1'b0;
   logic [1:0]        bus_addr = 2'd0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [N_WAKE-1:0] wake_pin = 2'b01;
   logic              pwr_en, alarm_irq;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   alarm_pwr_ctl #(.TIME_W(TIME_W), .N_WAKE(N_WAKE), .SYNC_STAGES(2)) u_alarm_pwr_ctl (
      .clk(clk), .rst_n(rst_n), .time_now(time_now), .time_tick(time_tick),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .wake_pin(wake_pin), .pwr_en(pwr_en),
      .alarm_irq(alarm_irq));

   localparam logic [31:0] K1 = 32'h5A3C_0F11;
   localparam logic [31:0] K2 = 32'hA5C3_F0EE;
   localparam logic [23:0] ALM = 24'h123456;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic tick(input logic [23:0] t);
      @(negedge clk);
      time_now = t; time_tick = 1'b1;
      @(negedge clk);
      time_tick = 1'b0;
   endtask

   task automatic unlock();
      wr(2'd0, K1);
      wr(2'd0, K2);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 pwr_en", {31'b0, pwr_en}, 32'd1);
      check("R1 irq", {31'b0, alarm_irq}, 32'd0);
      rd(2'd2, v); check("R1 ctrl", v, 32'd0);
      rd(2'd3, v); check("R1 status", v, 32'd0);
      rd(2'd0, v); check("R1 locked", v, 32'd0);
   endtask

   task automatic t_lock();
      logic [31:0] v;
      wr(2'd2, 32'h0000_0003);
      rd(2'd2, v); check("R2 ctrl locked", v, 32'd0);
      wr(2'd1, {8'h0, ALM});
      rd(2'd1, v); check("R2 alarm locked", v, 32'd0);
      wr(2'd0, K1); wr(2'd0, 32'h1);
      rd(2'd0, v); check("R9 wrong second key", v, 32'd0);
      wr(2'd0, K2);
      rd(2'd0, v); check("R9 second key alone", v, 32'd0);
      unlock();
      rd(2'd0, v); check("R9 unlocked", v, 32'd1);
      wr(2'd0, 32'h0);
      rd(2'd0, v); check("R9 relock", v, 32'd0);
      unlock();
      wr(2'd1, {8'h0, ALM});
      rd(2'd1, v); check("R2 alarm unlocked", v, {8'h0, ALM});
   endtask

   task automatic t_flag();
      logic [31:0] v;
      wr(2'd2, 32'h0000_0002);
      tick(24'h123457);
      rd(2'd3, v); check("R3 mismatch", v, 32'd0);
      @(negedge clk); time_now = ALM;
      @(negedge clk);
      rd(2'd3, v); check("R3 no strobe", v, 32'd0);
      tick(ALM);
      rd(2'd3, v); check("R3 hit sets flag", v, 32'd1);
      check("R4 irq on", {31'b0, alarm_irq}, 32'd1);
      check("R5 no ctl stays on", {31'b0, pwr_en}, 32'd1);
      wr(2'd3, 32'h0);
      rd(2'd3, v); check("R3 write 0 keeps", v, 32'd1);
      wr(2'd2, 32'h0);
      check("R4 irq masked", {31'b0, alarm_irq}, 32'd0);
      wr(2'd3, 32'h1);
      rd(2'd3, v); check("R3 w1c clears", v, 32'd0);
   endtask

   task automatic t_off_wake();
      wr(2'd2, 32'h0000_0001);
      tick(ALM);
      check("R5 alarm turns off", {31'b0, pwr_en}, 32'd0);
      wake_pin[0] = 1'b0;
      repeat (4) @(negedge clk);
      check("R6 disabled wake ignored", {31'b0, pwr_en}, 32'd0);
      wake_pin[0] = 1'b1;
      wr(2'd2, 32'h0000_0101);
      repeat (3) @(negedge clk);
      check("R6 idle high no wake", {31'b0, pwr_en}, 32'd0);
      wake_pin[0] = 1'b0;
      repeat (2) @(negedge clk);
      check("R6 not yet after two edges", {31'b0, pwr_en}, 32'd0);
      @(negedge clk);
      check("R6 R7 active-low wake on", {31'b0, pwr_en}, 32'd1);
      wake_pin[0] = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_pol();
      wr(2'd2, 32'h0002_0201);
      tick(ALM);
      check("R5 off again", {31'b0, pwr_en}, 32'd0);
      repeat (4) @(negedge clk);
      check("R7 active-high pin low stays off", {31'b0, pwr_en}, 32'd0);
      wake_pin[1] = 1'b1;
      repeat (3) @(negedge clk);
      check("R7 active-high wake on", {31'b0, pwr_en}, 32'd1);
   endtask

   task automatic t_prio();
      tick(ALM);
      check("R8 alarm wins while on", {31'b0, pwr_en}, 32'd0);
      @(negedge clk);
      check("R8 wake restores next edge", {31'b0, pwr_en}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lock();
      t_flag();
      t_off_wake();
      t_pol();
      t_prio();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule